// File: doc/BRIEF.md
# Reloadable Distributed-Arithmetic Partial-Sum Table

This block supplies the lookup table of a bit-serial distributed-arithmetic FIR filter from RAM rather than from fixed contents. Each cycle the filter presents one address, whose bit k is bit b of tap sample k, and one cycle later receives the sum of the coefficients selected by that address. Because the contents are built from a coefficient register bank at runtime, every channel can carry its own filter and an adaptive loop can change coefficients as it runs.

Two banks of the table are held. One bank, the active bank, answers lookups. The other, the shadow bank, is rebuilt from the current coefficients by an incremental generator. The generator forms each entry from an entry already written plus one coefficient, so it writes one entry per cycle per write lane. A swap request exchanges the banks once a rebuild has finished, so the filter never waits for a rebuild. A two-lane build, meant for symmetric filters where the fill time is critical, writes the lower and upper half of the table together and finishes in half the cycles.

Top module: `da_table_reloader`

## Requirements
- R1: After reset, load_busy and load_done are 0, lk_data is 0 and every entry of both banks reads 0.
- R2: Once a table is active, a lookup at address a returns the sum of coefficients k (coefficient index k as written through coef_idx) for every bit k that is 1 in a; address 0 returns 0 and address 1 returns coefficient 0.
- R3: Entries are EW = CW + ceil(log2(TAPS)) bits, two's complement, with coefficients sign-extended, so the extreme sums (all coefficients at the most negative or most positive value) come back exactly.
- R4: With FILL_LANES = 1 a build accepted at a clock edge ends with load_done high for exactly one cycle after the 2^TAPS-th following edge; load_busy is high in between.
- R5: With FILL_LANES = 2 the same build ends after 2^(TAPS-1) edges.
- R6: lk_data is registered: the value after an edge is the active-bank entry at the lk_addr sampled on that edge, and a build of the shadow bank does not change it.
- R7: A swap_req sampled while idle with a finished build waiting makes the rebuilt bank active; a lookup sampled on that same edge still reads the old bank.
- R8: A swap_req sampled when no finished build is waiting (none done since the last swap) is dropped and the active bank stays.
- R9: A swap_req sampled during a build is held and carried out on the edge that writes the last entry.
- R10: Coefficient writes and load_start sampled while a build runs are ignored; the build uses the coefficients present when it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | IW | Coefficient index to write |
| coef_data | input | CW | Signed coefficient value |
| load_start | input | 1 | Begin building the shadow bank (one-cycle pulse) |
| load_busy | output | 1 | Build in progress |
| load_done | output | 1 | One-cycle pulse when a build completes |
| swap_req | input | 1 | Request to make the rebuilt bank active |
| lk_addr | input | TAPS | Lookup address, one bit per tap |
| lk_data | output | EW | Registered signed partial sum |

## Verification
The in-line properties take for granted that load_start, swap_req and coef_we are single-cycle pulses driven on clean cycle boundaries and that coefficients fit CW bits; the overflow property additionally relies on the entry width formula, which the stimulus stresses by loading all-minimum and all-maximum coefficient sets. Stimulus keeps every control pulse one cycle wide and places the disallowed ones (a coefficient write, a second start, an early swap) only inside a running build or right after a swap, where the requirements define them as ignored or deferred. Two builds of the block, one and two write lanes, receive identical stimulus so that the bank contents are compared against one model while the fill lengths differ.

// File: rtl/da_tbl_pkg.sv
package da_tbl_pkg;

   // Width of a partial sum of TAPS signed CW-bit coefficients.
   function automatic int calc_entry_w(input int cw, input int taps);
      return cw + $clog2(taps);
   endfunction

   // Width of a coefficient index.
   function automatic int calc_idx_w(input int taps);
      return (taps > 1) ? $clog2(taps) : 1;
   endfunction

endpackage

// File: rtl/da_coef_bank.sv
module da_coef_bank #(
   parameter int TAPS = 4,
   parameter int CW   = 8,
   parameter int IW   = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IW-1:0]        wr_idx,
   input  logic [CW-1:0]        wr_data,
   input  logic                 lock,
   output logic [TAPS*CW-1:0]   coef_flat
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coef_flat <= '0;
      end else if (wr_en && !lock && (int'(wr_idx) < TAPS)) begin
         coef_flat[int'(wr_idx)*CW +: CW] <= wr_data;
      end
   end

   // Coefficients are frozen for the length of a build.
   assert_coef_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && wr_en) |=> $stable(coef_flat));

endmodule

// File: rtl/da_fill_gen.sv
module da_fill_gen #(
   parameter int TAPS  = 4,
   parameter int CW    = 8,
   parameter int EW    = 10,
   parameter int LANES = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [TAPS*CW-1:0]   coef_flat,
   input  logic [EW-1:0]        rd_data,
   output logic [TAPS-1:0]      rd_addr,
   output logic                 busy,
   output logic                 fin,
   output logic                 done,
   output logic [TAPS-1:0]      wr_a0,
   output logic [EW-1:0]        wr_d0,
   output logic                 wr_en1,
   output logic [TAPS-1:0]      wr_a1,
   output logic [EW-1:0]        wr_d1
);

   localparam int SW = (LANES == 2) ? TAPS - 1 : TAPS;
   localparam logic [SW-1:0] LAST = {SW{1'b1}};
   localparam logic [TAPS-1:0] TOP_BIT = TAPS'(1) << (TAPS - 1);

   logic [SW-1:0] step;
   logic signed [EW:0] sum0_w, sum1_w;
   logic signed [EW-1:0] c_hi, c_top;
   int hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         step <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               step <= '0;
            end
         end else begin
            if (step == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
            step <= step + 1'b1;
         end
      end
   end

   assign fin   = busy && (step == LAST);
   assign wr_a0 = TAPS'(step);

   // Entry a = entry(a without its top set bit) + coefficient of that bit.
   always_comb begin
      hi = 0;
      for (int i = 0; i < TAPS; i++) begin
         if (wr_a0[i]) hi = i;
      end
      rd_addr = wr_a0 & ~(TAPS'(1) << hi);
      c_hi    = EW'($signed(coef_flat[hi*CW +: CW]));
      c_top   = EW'($signed(coef_flat[(TAPS-1)*CW +: CW]));
      if (wr_a0 == '0) sum0_w = '0;
      else sum0_w = (EW+1)'($signed(rd_data)) + (EW+1)'(c_hi);
      wr_d0  = sum0_w[EW-1:0];
      sum1_w = (EW+1)'($signed(wr_d0)) + (EW+1)'(c_top);
   end

   generate
      if (LANES == 2) begin : g_dual
         assign wr_en1 = busy;
         assign wr_a1  = wr_a0 | TOP_BIT;
         assign wr_d1  = sum1_w[EW-1:0];
      end else begin : g_single
         assign wr_en1 = 1'b0;
         assign wr_a1  = '0;
         assign wr_d1  = '0;
      end
   endgenerate

   always_comb begin
      if (rst_n && busy) begin
         assert_no_overflow_R3: assert (sum0_w[EW] == sum0_w[EW-1]);
         if (LANES == 2) begin
            assert_no_overflow_lane1_R3: assert (sum1_w[EW] == sum1_w[EW-1]);
         end
      end
   end

   assert_fill_begins_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (step == '0));
   assert_done_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (done && !busy));

endmodule

// File: rtl/da_table_pair.sv
module da_table_pair #(
   parameter int TAPS = 4,
   parameter int EW   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_bank,
   input  logic              wr_en0,
   input  logic [TAPS-1:0]   wr_a0,
   input  logic [EW-1:0]     wr_d0,
   input  logic              wr_en1,
   input  logic [TAPS-1:0]   wr_a1,
   input  logic [EW-1:0]     wr_d1,
   input  logic [TAPS-1:0]   sh_addr,
   output logic [EW-1:0]     sh_data,
   input  logic [TAPS-1:0]   lk_addr,
   output logic [EW-1:0]     lk_data
);

   localparam int DEPTH = 1 << TAPS;

   logic [EW-1:0] mem [2][DEPTH];
   logic sh_bank;

   assign sh_bank = ~act_bank;
   assign sh_data = mem[sh_bank][sh_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < DEPTH; a++) begin
               mem[b][a] <= '0;
            end
         end
         lk_data <= '0;
      end else begin
         if (wr_en0) mem[sh_bank][wr_a0] <= wr_d0;
         if (wr_en1) mem[sh_bank][wr_a1] <= wr_d1;
         lk_data <= mem[act_bank][lk_addr];
      end
   end

endmodule

// File: rtl/da_table_reloader.sv
module da_table_reloader
   import da_tbl_pkg::*;
#(
   parameter int TAPS       = 4,
   parameter int CW         = 8,
   parameter int FILL_LANES = 1,
   localparam int EW        = calc_entry_w(CW, TAPS),
   localparam int IW        = calc_idx_w(TAPS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             coef_we,
   input  logic [IW-1:0]    coef_idx,
   input  logic [CW-1:0]    coef_data,
   input  logic             load_start,
   output logic             load_busy,
   output logic             load_done,
   input  logic             swap_req,
   input  logic [TAPS-1:0]  lk_addr,
   output logic [EW-1:0]    lk_data
);

   generate
      if (TAPS < 1 || TAPS > 10) begin : g_bad_taps
         $error("TAPS must lie in 1..10");
      end
      if (CW < 2) begin : g_bad_cw
         $error("CW must be at least 2");
      end
      if (FILL_LANES != 1 && FILL_LANES != 2) begin : g_bad_lanes
         $error("FILL_LANES must be 1 or 2");
      end
      if (FILL_LANES == 2 && TAPS < 2) begin : g_bad_dual
         $error("two fill lanes need at least two taps");
      end
   endgenerate

   logic [TAPS*CW-1:0] coef_flat;
   logic [TAPS-1:0]    rd_addr, wr_a0, wr_a1;
   logic [EW-1:0]      rd_data, wr_d0, wr_d1;
   logic               wr_en1, fin;
   logic               act_bank, sh_ready, swap_pend;

   da_coef_bank #(.TAPS(TAPS), .CW(CW), .IW(IW)) i_coef (
      .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_idx(coef_idx),
      .wr_data(coef_data), .lock(load_busy), .coef_flat(coef_flat));

   da_fill_gen #(.TAPS(TAPS), .CW(CW), .EW(EW), .LANES(FILL_LANES)) i_gen (
      .clk(clk), .rst_n(rst_n), .start(load_start), .coef_flat(coef_flat),
      .rd_data(rd_data), .rd_addr(rd_addr), .busy(load_busy), .fin(fin),
      .done(load_done), .wr_a0(wr_a0), .wr_d0(wr_d0), .wr_en1(wr_en1),
      .wr_a1(wr_a1), .wr_d1(wr_d1));

   da_table_pair #(.TAPS(TAPS), .EW(EW)) i_tbl (
      .clk(clk), .rst_n(rst_n), .act_bank(act_bank),
      .wr_en0(load_busy), .wr_a0(wr_a0), .wr_d0(wr_d0),
      .wr_en1(wr_en1), .wr_a1(wr_a1), .wr_d1(wr_d1),
      .sh_addr(rd_addr), .sh_data(rd_data),
      .lk_addr(lk_addr), .lk_data(lk_data));

   // Bank exchange control.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_bank  <= 1'b0;
         sh_ready  <= 1'b0;
         swap_pend <= 1'b0;
      end else if (fin) begin
         if (swap_pend || swap_req) begin
            act_bank  <= ~act_bank;
            sh_ready  <= 1'b0;
         end else begin
            sh_ready  <= 1'b1;
         end
         swap_pend <= 1'b0;
      end else if (load_busy) begin
         if (swap_req) swap_pend <= 1'b1;
      end else if (load_start) begin
         sh_ready <= 1'b0;
      end else if (swap_req && sh_ready) begin
         act_bank <= ~act_bank;
         sh_ready <= 1'b0;
      end
   end

   assert_swap_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_busy && !sh_ready && swap_req) |=> $stable(act_bank));
   assert_swap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_busy && !fin) |=> $stable(act_bank));
   assert_swap_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_done && $past(swap_pend)) |-> (act_bank != $past(act_bank)));
   assert_swap_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_busy && !load_start && sh_ready && swap_req) |=> (act_bank != $past(act_bank)));

endmodule

// File: tb/test_da_table_reloader.sv
module test_da_table_reloader;

   localparam int TAPS  = 4;
   localparam int CW    = 8;
   localparam int EW    = CW + $clog2(TAPS);
   localparam int IW    = $clog2(TAPS);
   localparam int DEPTH = 1 << TAPS;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            coef_we = 1'b0;
   logic [IW-1:0]   coef_idx = '0;
   logic [CW-1:0]   coef_data = '0;
   logic            load_start = 1'b0;
   logic            swap_req = 1'b0;
   logic [TAPS-1:0] lk_addr = '0;
   logic            busy_s, done_s, busy_d, done_d;
   logic [EW-1:0]   data_s, data_d;

   da_table_reloader #(.TAPS(TAPS), .CW(CW), .FILL_LANES(1)) i_da_table_reloader (
      .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
      .coef_data(coef_data), .load_start(load_start), .load_busy(busy_s),
      .load_done(done_s), .swap_req(swap_req), .lk_addr(lk_addr), .lk_data(data_s));

   da_table_reloader #(.TAPS(TAPS), .CW(CW), .FILL_LANES(2)) i_da_table_reloader_dual (
      .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
      .coef_data(coef_data), .load_start(load_start), .load_busy(busy_d),
      .load_done(done_d), .swap_req(swap_req), .lk_addr(lk_addr), .lk_data(data_d));

   int n_tests = 0;
   int n_fail  = 0;

   int act_model [DEPTH];
   int sh_model  [DEPTH];
   int cset      [TAPS];

   int    exp_q [$];
   string tag_q [$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   // Monitor: each lookup pushed at a falling edge is compared just after the next rising edge.
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         int e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(int'($signed(data_s)) == e, t, "lookup one-lane", int'($signed(data_s)), e);
         check(int'($signed(data_d)) == e, t, "lookup two-lane", int'($signed(data_d)), e);
      end
   end

   // Driver: present an address and queue the expected active-bank value.
   task automatic push_lookup(input int a, input string t);
      lk_addr = TAPS'(a);
      exp_q.push_back(act_model[a]);
      tag_q.push_back(t);
   endtask

   task automatic lookup_all(input string t);
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         push_lookup(a, t);
      end
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic build_shadow_model();
      for (int a = 0; a < DEPTH; a++) begin
         int s = 0;
         for (int k = 0; k < TAPS; k++) begin
            if (a[k]) s += cset[k];
         end
         sh_model[a] = s;
      end
   endtask

   task automatic write_coefs();
      for (int k = 0; k < TAPS; k++) begin
         @(negedge clk);
         coef_we   = 1'b1;
         coef_idx  = IW'(k);
         coef_data = CW'(cset[k]);
      end
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   // Run a build; optionally look up during it, or inject ignored / deferred stimulus.
   task automatic run_fill(input bit look_during, input bit disturb, input string t);
      int cs = -1;
      int cd = -1;
      @(negedge clk);
      load_start = 1'b1;
      for (int n = 0; n < 40 && (cs < 0 || cd < 0); n++) begin
         @(negedge clk);
         load_start = 1'b0;
         coef_we    = 1'b0;
         swap_req   = 1'b0;
         if (n == 0) check(busy_s && busy_d, "R4", "busy during build", int'(busy_s & busy_d), 1);
         if (disturb && n == 1) begin
            coef_we    = 1'b1;
            coef_idx   = IW'(TAPS - 1);
            coef_data  = CW'(5);
            load_start = 1'b1;
            swap_req   = 1'b1;
         end
         if (look_during) push_lookup(n % DEPTH, "R6");
         if (done_s && cs < 0) cs = n;
         if (done_d && cd < 0) cd = n;
      end
      coef_we = 1'b0; load_start = 1'b0; swap_req = 1'b0;
      check(cs == DEPTH, "R4", {t, " one-lane fill cycles"}, cs, DEPTH);
      check(cd == DEPTH / 2, "R5", {t, " two-lane fill cycles"}, cd, DEPTH / 2);
      @(negedge clk);
      check(!done_s && !busy_s, "R4", "done is a single pulse", int'(done_s | busy_s), 0);
      @(negedge clk);
   endtask

   task automatic do_swap(input string t);
      @(negedge clk);
      swap_req = 1'b1;
      push_lookup(DEPTH - 1, "R7");
      for (int a = 0; a < DEPTH; a++) act_model[a] = sh_model[a];
      @(negedge clk);
      swap_req = 1'b0;
      lookup_all(t);
   endtask

   task automatic dead_swap();
      @(negedge clk);
      swap_req = 1'b1;
      @(negedge clk);
      swap_req = 1'b0;
      lookup_all("R8");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) act_model[a] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state.
      check(!busy_s && !busy_d, "R1", "busy after reset", int'(busy_s | busy_d), 0);
      check(!done_s && !done_d, "R1", "done after reset", int'(done_s | done_d), 0);
      check(data_s == '0 && data_d == '0, "R1", "lookup after reset",
            int'($signed(data_s)), 0);
      lookup_all("R1");

      // R2/R6/R4/R5/R7: mixed-sign set, lookups while building, then swap.
      cset = '{3, -5, 17, -64};
      write_coefs();
      build_shadow_model();
      run_fill(1'b1, 1'b0, "set A");
      do_swap("R2");

      // R8: a second swap with nothing rebuilt is dropped.
      dead_swap();

      // R3/R9/R10: all-minimum set, with ignored write, ignored restart and early swap.
      cset = '{-128, -128, -128, -128};
      write_coefs();
      build_shadow_model();
      run_fill(1'b0, 1'b1, "set B");
      for (int a = 0; a < DEPTH; a++) act_model[a] = sh_model[a];
      lookup_all("R9");
      check(act_model[DEPTH-1] == -512, "R3", "model extreme", act_model[DEPTH-1], -512);
      // R10: busy must have ended once, not been restarted by the mid-build start.
      check(!busy_s && !busy_d, "R10", "no restart from start during build",
            int'(busy_s | busy_d), 0);
      dead_swap();

      // R3: all-maximum set.
      cset = '{127, 127, 127, 127};
      write_coefs();
      build_shadow_model();
      run_fill(1'b1, 1'b0, "set C");
      do_swap("R3");

      repeat (3) @(negedge clk);
      report();
   end

endmodule